// File: doc/BRIEF.md
# TDM Serial Timeslot Output Assigner

This block places three channel payloads on one serial data line inside a time-division frame. Two byte-wide bearer channels and a two-bit signalling channel are captured at each frame sync pulse. Each payload is then shifted out, most significant bit first, at a programmable position. Positions are counted in bit clocks from the frame sync. An output enable marks the clocks in which the line is actually driven.

In direct placement, each channel has its own 8-bit start code N, and its slot begins at position 2·N. The bearer slots are 8 or 10 clocks long, depending on a width control. In indexed placement, a 3-bit slot index, taken from the low bits of the signalling channel's start code, selects one of eight fixed 32-clock channel groups. All three payloads go into that group, and the other start codes have no effect. Slots that collide are resolved by a fixed priority, and the collision is remembered in a sticky flag. Slots that would run past the end of the 512-clock frame are cut off.

Top module: `tdm_slot_tx`

## Requirements
- R1: A frame sync sampled high at a rising clock edge makes that edge position 0 of a new frame, and every later edge advances the position by one, up to position 511.
- R2: In direct placement (`indexed_mode`=0), a channel with start code N begins its slot at position 2·N. This applies to each of the first bearer (`b1_start`), the second bearer (`b2_start`) and the signalling channel (`d_start`).
- R3: A bearer slot carries its byte most significant bit first, with bit 7−k at slot offset k for k = 0 to 7.
- R4: With `wide_slot`=1 in direct placement, a bearer slot lasts 10 clocks. Offsets 8 and 9 drive `sdout`=0 with `sdout_oe`=1. With `wide_slot`=0, a bearer slot lasts 8 clocks.
- R5: The signalling slot lasts 2 clocks: bit 1 of `d_data` at offset 0, then bit 0 at offset 1.
- R6: After position 511, nothing is driven until the next frame sync. Any part of a slot beyond position 511 is dropped.
- R7: `sdout_oe` is 1 only in clocks that belong to a slot. When `sdout_oe` is 0, `sdout` is 0. After reset, both outputs and `overlap_flag` are 0.
- R8: In indexed placement (`indexed_mode`=1), the index k = `d_start[2:0]` places the first bearer at 32·k, the second bearer at 32·k+8 and the signalling slot at 32·k+16. In this mode the bearer slots are always 8 clocks long, and `b1_start`, `b2_start` and `wide_slot` are ignored. The selection is invalid if `d_start[7:3]` is nonzero, or if `four_slot_rate`=1 and k ≥ 4. An invalid selection drives no slot.
- R9: Where slots overlap, the first bearer wins over the second bearer, and the second bearer wins over the signalling channel. Any clock in which two or more slots are active sets `overlap_flag`, which stays set until reset.
- R10: Channel data is captured at the frame sync edge. A change on `b1_data`, `b2_data` or `d_data` during a frame does not alter that frame's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync | input | 1 | Frame sync, one clock wide |
| b1_data | input | 8 | First bearer payload |
| b2_data | input | 8 | Second bearer payload |
| d_data | input | 2 | Signalling payload |
| b1_start | input | 8 | First bearer start code (direct placement) |
| b2_start | input | 8 | Second bearer start code (direct placement) |
| d_start | input | 8 | Signalling start code; in indexed placement, bits 2:0 are the slot index |
| wide_slot | input | 1 | 1 selects 10-clock bearer slots in direct placement |
| indexed_mode | input | 1 | 1 selects indexed placement |
| four_slot_rate | input | 1 | 1 marks indexes 4 to 7 as invalid |
| sdout | output | 1 | Serial data output |
| sdout_oe | output | 1 | Output enable for sdout |
| overlap_flag | output | 1 | Sticky slot-collision flag |

## Verification
The hardest situations to reach from the ports are the edge of the frame and the moment of collision. At the frame edge, a slot starting at position 510 must be cut off after two clocks and the line must then stay quiet. At a collision, the priority winner must show its own bits while the flag rises in exactly that clock. The bench reaches both with chosen start codes: a bearer at code 255 in 10-clock mode, and three slots packed so that they overlap in part. It also sweeps all eight indexes under both rate settings, and it alters the payload inputs during a frame. Every position of every frame is compared against an arithmetic model that uses the payloads captured at the sync.

// File: rtl/tdm_slot_pkg.sv
`timescale 1ns/1ps
package tdm_slot_pkg;
    localparam int POS_W     = 9;              // 512-clock frame
    localparam int DATA_W    = 8;              // bearer payload bits
    localparam int D_W       = 2;              // signalling payload bits
    localparam int OFF_W     = 4;              // slot offset / length width
    localparam int IDX_W     = $clog2(DATA_W);
    localparam int D_IDX_W   = (D_W > 1) ? $clog2(D_W) : 1;
    localparam int GROUP_SH  = 5;              // indexed group spacing 32
    localparam int NUM_CH    = 3;
    localparam int B_NARROW  = DATA_W;
    localparam int B_WIDE    = DATA_W + 2;

    typedef logic [POS_W-1:0] pos_t;

    typedef struct packed {
        pos_t              cnt;
        logic              run;
        logic [DATA_W-1:0] b1;
        logic [DATA_W-1:0] b2;
        logic [D_W-1:0]    d;
        logic              sd;
        logic              oe;
        logic              ovl;
    } tx_state_t;
endpackage

// File: rtl/tdm_frame_timer.sv
`timescale 1ns/1ps
module tdm_frame_timer #(
    parameter int POS_W = 9
) (
    input  logic [POS_W-1:0] cnt_q,
    input  logic             run_q,
    input  logic             fsync,
    output logic [POS_W-1:0] cnt_d,
    output logic             run_d
);
    localparam logic [POS_W-1:0] LAST = {POS_W{1'b1}};

    always_comb begin
        cnt_d = cnt_q;
        run_d = run_q;
        if (fsync) begin
            cnt_d = '0;
            run_d = 1'b1;
        end else if (run_q) begin
            if (cnt_q == LAST) begin
                run_d = 1'b0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tdm_slot_window.sv
`timescale 1ns/1ps
module tdm_slot_window #(
    parameter int POS_W = 9,
    parameter int OFF_W = 4
) (
    input  logic [POS_W-1:0] pos,
    input  logic [POS_W-1:0] start,
    input  logic [OFF_W-1:0] len,
    input  logic             en,
    output logic             active,
    output logic [OFF_W-1:0] off
);
    logic [POS_W-1:0] diff;

    always_comb begin
        diff   = pos - start;
        active = en && (pos >= start) && (diff < POS_W'(len));
        off    = diff[OFF_W-1:0];
    end
endmodule

// File: rtl/tdm_slot_tx.sv
`timescale 1ns/1ps
module tdm_slot_tx
    import tdm_slot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic [DATA_W-1:0] b1_data,
    input  logic [DATA_W-1:0] b2_data,
    input  logic [D_W-1:0]    d_data,
    input  logic [7:0]        b1_start,
    input  logic [7:0]        b2_start,
    input  logic [7:0]        d_start,
    input  logic              wide_slot,
    input  logic              indexed_mode,
    input  logic              four_slot_rate,
    output logic              sdout,
    output logic              sdout_oe,
    output logic              overlap_flag
);
    tx_state_t state_q, state_d;

    pos_t                         cnt_d;
    logic                         run_d;
    logic [NUM_CH-1:0][POS_W-1:0] start_a;
    logic [NUM_CH-1:0][OFF_W-1:0] len_a;
    logic [NUM_CH-1:0][OFF_W-1:0] off_a;
    logic [NUM_CH-1:0]            act;
    logic                         bad_sel;
    logic                         win_en;
    logic [2:0]                   grp;
    pos_t                         grp_base;

    function automatic logic bearer_bit(logic [DATA_W-1:0] v, logic [OFF_W-1:0] o);
        logic [OFF_W-1:0] idx;
        if (o >= OFF_W'(DATA_W)) return 1'b0;
        idx = OFF_W'(DATA_W - 1) - o;
        return v[idx[IDX_W-1:0]];
    endfunction

    function automatic logic sig_bit(logic [D_W-1:0] v, logic [OFF_W-1:0] o);
        logic [OFF_W-1:0] idx;
        idx = OFF_W'(D_W - 1) - o;
        return v[idx[D_IDX_W-1:0]];
    endfunction

    tdm_frame_timer #(.POS_W(POS_W)) u_timer (
        .cnt_q (state_q.cnt),
        .run_q (state_q.run),
        .fsync (fsync),
        .cnt_d (cnt_d),
        .run_d (run_d)
    );

    // Placement: direct start codes or indexed channel groups
    always_comb begin
        grp      = d_start[2:0];
        grp_base = POS_W'({grp, {GROUP_SH{1'b0}}});
        bad_sel  = indexed_mode && ((|d_start[7:3]) || (four_slot_rate && grp[2]));
        win_en   = run_d && !bad_sel;
        if (indexed_mode) begin
            start_a[0] = grp_base;
            start_a[1] = grp_base + POS_W'(DATA_W);
            start_a[2] = grp_base + POS_W'(2 * DATA_W);
            len_a[0]   = OFF_W'(B_NARROW);
            len_a[1]   = OFF_W'(B_NARROW);
        end else begin
            start_a[0] = {b1_start, 1'b0};
            start_a[1] = {b2_start, 1'b0};
            start_a[2] = {d_start, 1'b0};
            len_a[0]   = wide_slot ? OFF_W'(B_WIDE) : OFF_W'(B_NARROW);
            len_a[1]   = wide_slot ? OFF_W'(B_WIDE) : OFF_W'(B_NARROW);
        end
        len_a[2] = OFF_W'(D_W);
    end

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_win
            tdm_slot_window #(.POS_W(POS_W), .OFF_W(OFF_W)) u_win (
                .pos    (cnt_d),
                .start  (start_a[g]),
                .len    (len_a[g]),
                .en     (win_en),
                .active (act[g]),
                .off    (off_a[g])
            );
        end
    endgenerate

    always_comb begin
        state_d     = state_q;
        state_d.cnt = cnt_d;
        state_d.run = run_d;
        if (fsync) begin
            state_d.b1 = b1_data;
            state_d.b2 = b2_data;
            state_d.d  = d_data;
        end
        state_d.oe = |act;
        state_d.sd = 1'b0;
        if (act[0]) begin
            state_d.sd = bearer_bit(state_d.b1, off_a[0]);
        end else if (act[1]) begin
            state_d.sd = bearer_bit(state_d.b2, off_a[1]);
        end else if (act[2]) begin
            state_d.sd = sig_bit(state_d.d, off_a[2]);
        end
        state_d.ovl = state_q.ovl | ($countones(act) > 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign sdout        = state_q.sd;
    assign sdout_oe     = state_q.oe;
    assign overlap_flag = state_q.ovl;
endmodule

// File: rtl/tdm_slot_tx_chk.sv
`timescale 1ns/1ps
module tdm_slot_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fsync,
    input logic [7:0] d_start,
    input logic       indexed_mode,
    input logic       four_slot_rate,
    input logic       sdout,
    input logic       sdout_oe,
    input logic       overlap_flag
);
    logic [9:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_q <= '1;
        else if (fsync)           since_q <= '0;
        else if (since_q != '1)   since_q <= since_q + 1'b1;
    end

    assert_quiet_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sdout_oe |-> !sdout);

    assert_frame_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q >= 10'd512) |-> !sdout_oe);

    assert_bad_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (indexed_mode && ((|d_start[7:3]) || (four_slot_rate && d_start[2])))
        |=> !sdout_oe);

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_flag |=> overlap_flag);
endmodule

bind tdm_slot_tx tdm_slot_tx_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fsync          (fsync),
    .d_start        (d_start),
    .indexed_mode   (indexed_mode),
    .four_slot_rate (four_slot_rate),
    .sdout          (sdout),
    .sdout_oe       (sdout_oe),
    .overlap_flag   (overlap_flag)
);

// File: tb/tdm_slot_tx_tb.sv
`timescale 1ns/1ps
module tdm_slot_tx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic [7:0] b1_data = '0, b2_data = '0;
    logic [1:0] d_data = '0;
    logic [7:0] b1_start = 8'h00, b2_start = 8'h04, d_start = 8'h08;
    logic       wide_slot = 1'b0, indexed_mode = 1'b0, four_slot_rate = 1'b0;
    logic       sdout, sdout_oe, overlap_flag;

    int errors = 0;
    int checks = 0;
    int frame_no = 0;
    logic [7:0] lb1, lb2;
    logic [1:0] ld;
    logic       exp_ovl = 1'b0;
    bit         finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    tdm_slot_tx u_dut (
        .clk(clk), .rst_n(rst_n), .fsync(fsync),
        .b1_data(b1_data), .b2_data(b2_data), .d_data(d_data),
        .b1_start(b1_start), .b2_start(b2_start), .d_start(d_start),
        .wide_slot(wide_slot), .indexed_mode(indexed_mode),
        .four_slot_rate(four_slot_rate),
        .sdout(sdout), .sdout_oe(sdout_oe), .overlap_flag(overlap_flag)
    );

    task automatic check(string req, int pos, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s pos=%0d {sd,oe,ovl} actual=%b expected=%b", req, pos, act, exp);
        end
    endtask

    // Model of one position: returns {sd,oe} and number of active slots
    task automatic model(int pos, output logic sd, output logic oe, output int n);
        int s[3];
        int l[3];
        bit bad;
        bad = indexed_mode && ((d_start[7:3] != 0) || (four_slot_rate && d_start[2]));
        if (indexed_mode) begin
            s[0] = 32 * d_start[2:0]; s[1] = s[0] + 8; s[2] = s[0] + 16;
            l[0] = 8; l[1] = 8;
        end else begin
            s[0] = 2 * b1_start; s[1] = 2 * b2_start; s[2] = 2 * d_start;
            l[0] = wide_slot ? 10 : 8; l[1] = l[0];
        end
        l[2] = 2;
        sd = 1'b0; oe = 1'b0; n = 0;
        for (int c = 0; c < 3; c++) begin
            if (!bad && pos >= s[c] && pos < s[c] + l[c]) begin
                int o;
                o = pos - s[c];
                n++;
                if (!oe) begin
                    oe = 1'b1;
                    if (c == 0)      sd = (o < 8) ? lb1[7 - o] : 1'b0;
                    else if (c == 1) sd = (o < 8) ? lb2[7 - o] : 1'b0;
                    else             sd = ld[1 - o];
                end
            end
        end
    endtask

    task automatic run_frame(string req, int change_at);
        logic esd, eoe;
        int n;
        frame_no++;
        @(negedge clk);
        b1_data = 8'hA5 ^ 8'(frame_no * 37);
        b2_data = 8'h3C ^ 8'(frame_no * 11);
        d_data  = 2'(frame_no);
        fsync = 1'b1;
        lb1 = b1_data; lb2 = b2_data; ld = d_data;
        @(negedge clk);
        fsync = 1'b0;
        for (int p = 0; p < 512; p++) begin
            if (p > 0) @(negedge clk);
            model(p, esd, eoe, n);
            if (n > 1) exp_ovl = 1'b1;
            check(req, p, {sdout, sdout_oe, overlap_flag}, {esd, eoe, exp_ovl});
            if (p == change_at) begin   // R10: mid-frame payload change
                b1_data = ~b1_data; b2_data = ~b2_data; d_data = ~d_data;
            end
        end
        @(negedge clk);
        check("R6", 512, {sdout, sdout_oe, overlap_flag}, {1'b0, 1'b0, exp_ovl});
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R7", -1, {sdout, sdout_oe, overlap_flag}, 3'b000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R7", -1, {sdout, sdout_oe, overlap_flag}, 3'b000);

        // R1 R2 R3 R5: default codes, 8-clock slots
        run_frame("R2", -1);
        b1_start = 8'd20; b2_start = 8'd47; d_start = 8'd90;
        run_frame("R3", -1);
        // R4: 10-clock bearer slots, adjacent
        wide_slot = 1'b1; b1_start = 8'd0; b2_start = 8'd5; d_start = 8'd10;
        run_frame("R4", -1);
        // R6: truncation at frame end
        b1_start = 8'd255; b2_start = 8'd100; d_start = 8'd254;
        run_frame("R6", -1);
        wide_slot = 1'b0; b1_start = 8'd30; b2_start = 8'd254; d_start = 8'd255;
        run_frame("R6", -1);
        // R10: payload inputs change inside the frame
        b1_start = 8'd2; b2_start = 8'd6; d_start = 8'd12;
        run_frame("R10", 3);
        // R8: indexed placement, all indexes, both rates, junk direct codes
        indexed_mode = 1'b1; wide_slot = 1'b1;
        b1_start = 8'd1; b2_start = 8'd2;
        for (int r = 0; r < 2; r++) begin
            four_slot_rate = r[0];
            for (int k = 0; k < 8; k++) begin
                d_start = 8'(k);
                run_frame("R8", -1);
            end
        end
        four_slot_rate = 1'b0; d_start = 8'h0B;
        run_frame("R8", -1);
        // R9: collisions, then a clean frame with the flag still set
        indexed_mode = 1'b0; wide_slot = 1'b1;
        b1_start = 8'd0; b2_start = 8'd2; d_start = 8'd3;
        run_frame("R9", -1);
        wide_slot = 1'b0; b1_start = 8'd40; b2_start = 8'd60; d_start = 8'd80;
        run_frame("R9", -1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule